// File: doc/BRIEF.md
# Conditional Search Qualifier

This block decides whether a device takes part in a conditional search. It holds three small registers (a channel mask, a channel polarity and a control/status byte) that are loaded through a simple register-write port. From these registers, the eight channel pin levels and the eight channel activity latch bits, it forms one response flag. A response is also forced while the power-on latch is set.

The control byte does four jobs. It picks the data source for every channel (pins or activity latches). It picks whether the per-channel matches are ORed or ANDed. It stores the reset-pin mode bit for the neighbouring port block. It carries the sticky power-on latch. Bit 7 reflects whether an external supply is present, and bits 4 to 6 are fixed at zero. The response is combinational: a register write becomes visible at the clock edge that captures it, and a change at the channel inputs is visible in the same cycle.

Top module: `cond_search_qual`

## Requirements
- R1: After reset, mask_o and pol_o read 00h and ctrl_o reads 08h while supply_ok_i is 0 (88h while it is 1).
- R2: Control bit 0 selects the channel data source: 0 takes pin_i, 1 takes act_i, for all channels together.
- R3: Channel i matches when mask bit i is 1 and the selected data bit i equals polarity bit i. Channels with a mask bit of 0 have no effect on hit_o.
- R4: With control bit 1 at 0 (OR term), hit_o is 1 when at least one selected channel matches.
- R5: With control bit 1 at 1 (AND term), hit_o is 1 when the mask is non-zero and every selected channel matches.
- R6: With mask 00h and control bit 3 at 0, hit_o is 0 in both the OR and the AND term.
- R7: Control bit 3 is the power-on latch. Reset sets it. A control write with data bit 3 at 0 clears it, and a write with data bit 3 at 1 leaves it unchanged. While it is 1, hit_o is 1.
- R8: Bits 6:4 of ctrl_o always read 0, and bit 7 always equals supply_ok_i. Control writes do not change these bits.
- R9: Control bit 2 is stored by control writes, read back in ctrl_o bit 2 and driven on rst_mode_o.
- R10: A write with wr_en_i at 1 takes effect at the rising clock edge. wr_sel_i = 0 writes the mask, 1 writes the polarity, 2 writes the control byte, and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 mask, 1 polarity, 2 control, 3 none |
| wr_data_i | input | DATA_W | Write data |
| pin_i | input | NUM_CH | Channel pin levels |
| act_i | input | NUM_CH | Channel activity latch bits |
| supply_ok_i | input | 1 | External supply present |
| mask_o | output | NUM_CH | Mask register readback |
| pol_o | output | NUM_CH | Polarity register readback |
| ctrl_o | output | 8 | Control/status readback |
| rst_mode_o | output | 1 | Reset-pin mode bit for the port block |
| hit_o | output | 1 | Conditional search response |

## Verification
Two functions can fall in the same cycle. One is a control write that clears the power-on latch or switches the source and term. The other is the evaluation of a channel pattern that would or would not qualify on its own. The bench applies both in one cycle: it holds a non-qualifying pattern while the latch-clearing write is pending. It then checks that hit_o is still forced high before the edge and follows the pattern alone after the edge. Random mask, polarity and channel data are swept in all four source/term combinations and compared with a reference computed arithmetically in the bench.

// File: rtl/cs_qual_pkg.sv
package cs_qual_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_POL  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  localparam int CTRL_SRC  = 0;
  localparam int CTRL_TERM = 1;
  localparam int CTRL_RMOD = 2;
  localparam int CTRL_POR  = 3;
  localparam int CTRL_W    = 8;
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_qual_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic              src_act_o,
  output logic              term_and_o,
  output logic              rst_mode_o,
  output logic              por_o
);
  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      pol_o      <= '0;
      src_act_o  <= 1'b0;
      term_and_o <= 1'b0;
      rst_mode_o <= 1'b0;
      por_o      <= 1'b1;
    end else if (wr_en_i) begin
      case (sel)
        SEL_MASK: mask_o <= wr_data_i[NUM_CH-1:0];
        SEL_POL:  pol_o  <= wr_data_i[NUM_CH-1:0];
        SEL_CTRL: begin
          src_act_o  <= wr_data_i[CTRL_SRC];
          term_and_o <= wr_data_i[CTRL_TERM];
          rst_mode_o <= wr_data_i[CTRL_RMOD];
          // latch may only be cleared by software
          por_o      <= por_o & wr_data_i[CTRL_POR];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cs_match.sv
module cs_match #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_CH-1:0] act_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [NUM_CH-1:0] pol_i,
  input  logic              src_act_i,
  output logic [NUM_CH-1:0] hit_vec_o,
  output logic [NUM_CH-1:0] miss_vec_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic data_bit;
    assign data_bit      = src_act_i ? act_i[i] : pin_i[i];
    assign hit_vec_o[i]  = mask_i[i] & (data_bit == pol_i[i]);
    assign miss_vec_o[i] = mask_i[i] & (data_bit != pol_i[i]);
  end
endmodule

// File: rtl/cs_combine.sv
module cs_combine #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] hit_vec_i,
  input  logic [NUM_CH-1:0] miss_vec_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              term_and_i,
  input  logic              por_i,
  output logic              hit_o
);
  logic any_hit, all_hit;
  assign any_hit = |hit_vec_i;
  // empty mask must not qualify in AND term
  assign all_hit = (|mask_i) & ~(|miss_vec_i);
  assign hit_o   = por_i | (term_and_i ? all_hit : any_hit);
endmodule

// File: rtl/cond_search_qual.sv
module cond_search_qual
  import cs_qual_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_CH-1:0] act_i,
  input  logic              supply_ok_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rst_mode_o,
  output logic              hit_o
);
  logic              src_act, term_and, por;
  logic [NUM_CH-1:0] hit_vec, miss_vec;

  cs_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .mask_o     (mask_o),
    .pol_o      (pol_o),
    .src_act_o  (src_act),
    .term_and_o (term_and),
    .rst_mode_o (rst_mode_o),
    .por_o      (por)
  );

  cs_match #(.NUM_CH(NUM_CH)) u_match (
    .pin_i      (pin_i),
    .act_i      (act_i),
    .mask_i     (mask_o),
    .pol_i      (pol_o),
    .src_act_i  (src_act),
    .hit_vec_o  (hit_vec),
    .miss_vec_o (miss_vec)
  );

  cs_combine #(.NUM_CH(NUM_CH)) u_comb (
    .hit_vec_i  (hit_vec),
    .miss_vec_i (miss_vec),
    .mask_i     (mask_o),
    .term_and_i (term_and),
    .por_i      (por),
    .hit_o      (hit_o)
  );

  assign ctrl_o = {supply_ok_i, 3'b000, por, rst_mode_o, term_and, src_act};
endmodule

// File: rtl/cs_qual_chk.sv
module cs_qual_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [NUM_CH-1:0] pin_i,
  input logic [NUM_CH-1:0] mask_o,
  input logic [NUM_CH-1:0] pol_o,
  input logic [7:0]        ctrl_o,
  input logic              supply_ok_i,
  input logic              hit_o
);
  a_r7_por_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[3] |-> hit_o);

  a_r7_por_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[3] |=> !ctrl_o[3]);

  a_r6_empty_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0 && !ctrl_o[3]) |-> !hit_o);

  a_r8_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[6:4] == 3'b000) && (ctrl_o[7] == supply_ok_i));

  a_r10_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mask_o) && $stable(pol_o) && $stable(ctrl_o[3:0])));

  a_r4_or_pin_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[1] && !ctrl_o[0] && ((~(pin_i ^ pol_o) & mask_o) != '0)) |-> hit_o);
endmodule

bind cond_search_qual cs_qual_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .pin_i       (pin_i),
  .mask_o      (mask_o),
  .pol_o       (pol_o),
  .ctrl_o      (ctrl_o),
  .supply_ok_i (supply_ok_i),
  .hit_o       (hit_o)
);

// File: tb/cond_search_qual_test.sv
`timescale 1ns/1ps
module cond_search_qual_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] pin_i = '0;
  logic [7:0] act_i = '0;
  logic       supply_ok_i = 1'b0;
  logic [7:0] mask_o, pol_o, ctrl_o;
  logic       rst_mode_o, hit_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic done = 1'b0;

  always #5 clk_i = ~clk_i;

  cond_search_qual uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .pin_i(pin_i), .act_i(act_i),
    .supply_ok_i(supply_ok_i), .mask_o(mask_o), .pol_o(pol_o),
    .ctrl_o(ctrl_o), .rst_mode_o(rst_mode_o), .hit_o(hit_o)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic rnd8(output logic [7:0] v);
    seed = nxt(seed);
    v = seed[15:8];
  endtask

  function automatic logic ref_hit(input logic [7:0] m, input logic [7:0] p,
                                   input logic [3:0] c, input logic [7:0] pn,
                                   input logic [7:0] ac);
    logic [7:0] src, eq;
    src = c[0] ? ac : pn;
    eq  = ~(src ^ p) & m;
    if (c[3]) return 1'b1;
    if (c[1]) return (m != 8'h00) && (eq == m);
    return eq != 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h0, 8'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] m, p, pn, ac;
    repeat (3) @(negedge clk_i);
    #1;
    // R1 reset state
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 pol", pol_o, 8'h00);
    chk("R1 ctrl", ctrl_o, 8'h08);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 ctrl after release", ctrl_o, 8'h08);
    supply_ok_i = 1'b1; #1;
    chk("R1 ctrl supply", ctrl_o, 8'h88);
    // R7 latch forces response with empty mask
    chk("R7 por forces hit", {7'b0, hit_o}, 8'h01);
    // R7 writing 1 keeps it; R8 fixed bits; R9 mode bit
    wr(2'd2, 8'hFC);
    chk("R8 R9 ctrl", ctrl_o, 8'h8C);
    chk("R9 rst_mode", {7'b0, rst_mode_o}, 8'h01);
    // R10 sel 3 changes nothing
    wr(2'd3, 8'hFF);
    chk("R10 none mask", mask_o, 8'h00);
    chk("R10 none pol", pol_o, 8'h00);
    chk("R10 none ctrl", ctrl_o, 8'h8C);
    // same-cycle: clear latch while pattern does not qualify
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    @(negedge clk_i);
    pin_i = 8'h00;
    wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_data_i = 8'h00;
    #1;
    chk("R7 still forced", {7'b0, hit_o}, 8'h01);
    @(negedge clk_i);
    wr_en_i = 1'b0; #1;
    chk("R7 cleared ctrl", ctrl_o, 8'h80);
    chk("R7 cleared hit", {7'b0, hit_o}, 8'h00);
    chk("R9 rst_mode clear", {7'b0, rst_mode_o}, 8'h00);
    wr(2'd2, 8'h08);
    chk("R7 cannot set", ctrl_o, 8'h80);
    supply_ok_i = 1'b0; #1;
    chk("R8 supply low", ctrl_o, 8'h00);
    // R6 empty mask both terms
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    pin_i = 8'h00; act_i = 8'h00; #1;
    chk("R6 empty OR", {7'b0, hit_o}, 8'h00);
    wr(2'd2, 8'h02);
    chk("R6 empty AND", {7'b0, hit_o}, 8'h00);
    wr(2'd2, 8'h03);
    chk("R6 empty AND act", {7'b0, hit_o}, 8'h00);
    // sweep all source/term combinations
    for (int mode = 0; mode < 4; mode++) begin
      wr(2'd2, {6'b0, mode[1:0]});
      for (int k = 0; k < 120; k++) begin
        rnd8(m); rnd8(p);
        if (k < 8) m = 8'h01 << k;
        else if (k < 12) m = 8'hFF;
        wr(2'd0, m);
        wr(2'd1, p);
        chk("R10 mask", mask_o, m);
        for (int j = 0; j < 4; j++) begin
          rnd8(pn); rnd8(ac);
          if (j == 0 && mode[1]) begin pn = p; ac = p; end
          pin_i = pn; act_i = ac; #1;
          chk(mode[1] ? (mode[0] ? "R5 R2 R3 AND act" : "R5 R3 AND pin")
                      : (mode[0] ? "R4 R2 R3 OR act" : "R4 R3 OR pin"),
              {7'b0, hit_o}, {7'b0, ref_hit(m, p, {2'b00, mode[1:0]}, pn, ac)});
          @(negedge clk_i);
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule